// File: doc/BRIEF.md
# Single-Entry Branch Loop Buffer

This block sits between the fetch stage and a branch-prediction table held in a synchronous RAM. For each lookup it either reads the table or, when a tight loop has been recognised, gives the next fetch address from one internal register. In that second case the table RAM is left idle for the cycle. The only purpose is lower power. The predicted address is the same on both paths, and so is its one-cycle latency.

The buffer keeps one entry: a branch address, the target that the table returned for it, a valid flag and a small saturating repeat counter. Each table read that returns data for an address other than the stored one replaces the entry. Resolved branches then train the counter. Once the counter reaches its threshold, lookups of the stored address are answered from the register. A not-taken outcome, a target that differs from the stored one, or a flush empties the entry.

Top module: `branch_loop_buf`

## Requirements
- R1: After reset no table read is issued, no prediction is presented and the entry is empty, so the first lookup of any address reads the table.
- R2: A lookup that the buffer does not serve drives `bpt_rd_en` high with `bpt_rd_addr` equal to the lookup address in the same cycle. In the next cycle `pred_valid` is 1, `pred_from_buf` is 0 and `pred_target` equals `bpt_rd_data`.
- R3: When table data returns and the entry is empty or holds a different address, the entry takes the read address and the returned data, and its counter becomes 0. Data that returns for the stored address leaves the entry unchanged.
- R4: A taken resolution of the stored address, with a target equal to the stored target, adds one to the 2-bit counter. The counter saturates at 3.
- R5: A lookup of the stored address while the counter is 3 and no flush is present keeps `bpt_rd_en` low in that cycle. In the next cycle it gives `pred_valid`=1, `pred_from_buf`=1 and `pred_target` equal to the stored target.
- R6: For any lookup, the `pred_target` of the following cycle equals the table content for that address, whichever source served it.
- R7: A not-taken resolution of the stored address empties the entry, and the next lookup of that address reads the table.
- R8: A taken resolution of the stored address whose target differs from the stored target empties the entry.
- R9: `flush` empties the entry and also stops a same-cycle lookup from being served by the buffer.
- R10: A resolution for an address other than the stored one, or one that arrives while the entry is empty, has no effect on the entry.
- R11: When several events fall in the same cycle, flush has the highest priority, then the loading of returned table data, then the resolution update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the entry |
| lookup_valid | input | 1 | A fetch lookup is present |
| lookup_addr | input | ADDR_W | Branch address looked up |
| bpt_rd_en | output | 1 | Table RAM read enable |
| bpt_rd_addr | output | ADDR_W | Table RAM read address |
| bpt_rd_data | input | TGT_W | Table RAM data, one cycle after the read |
| resolve_valid | input | 1 | A branch resolution is present |
| resolve_addr | input | ADDR_W | Address of the resolved branch |
| resolve_taken | input | 1 | 1 when the branch was taken |
| resolve_target | input | TGT_W | Resolved target |
| pred_valid | output | 1 | Prediction present (one cycle after lookup) |
| pred_target | output | TGT_W | Predicted next fetch address |
| pred_from_buf | output | 1 | 1 when the buffer supplied the prediction |

## Verification
On every cycle, the assertions check that a table read is followed by a table-sourced prediction, and that an unread lookup is followed by a buffer-sourced one. They also check that a flush, a not-taken outcome or a wrong target empties the entry, and that the counter holds its value when no event touches it. Three things can only be shown by the bench scenarios, which compare every prediction with the table content for its address: that the buffer's target matches the table, that training needs exactly three taken resolutions, and that events falling together resolve in the stated priority.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
   typedef enum logic [1:0] {
      PSRC_NONE  = 2'd0,
      PSRC_TABLE = 2'd1,
      PSRC_BUF   = 2'd2
   } psrc_e;
endpackage

// File: rtl/lbuf_match.sv
module lbuf_match #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 2,
   parameter int THRESH = 3
) (
   input  logic              ent_vld,
   input  logic [ADDR_W-1:0] ent_addr,
   input  logic [CNT_W-1:0]  ent_cnt,
   input  logic              flush,
   input  logic              lookup_valid,
   input  logic [ADDR_W-1:0] lookup_addr,
   input  logic              resolve_valid,
   input  logic [ADDR_W-1:0] resolve_addr,
   output logic              serve_hit,
   output logic              res_hit
);
   localparam logic [CNT_W-1:0] SERVE_LVL = CNT_W'(THRESH);

   logic trained;
   assign trained   = ent_vld && (ent_cnt >= SERVE_LVL);
   assign serve_hit = lookup_valid && !flush && trained && (lookup_addr == ent_addr);
   assign res_hit   = resolve_valid && ent_vld && (resolve_addr == ent_addr);
endmodule

// File: rtl/lbuf_entry.sv
module lbuf_entry #(
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 32,
   parameter int CNT_W     = 2,
   parameter int THRESH    = 3,
   parameter bit CHECK_TGT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [TGT_W-1:0]  ld_tgt,
   input  logic              res_hit,
   input  logic              res_taken,
   input  logic [TGT_W-1:0]  res_tgt,
   output logic              ent_vld,
   output logic [ADDR_W-1:0] ent_addr,
   output logic [TGT_W-1:0]  ent_tgt,
   output logic [CNT_W-1:0]  ent_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (THRESH < 1 || THRESH > (1 << CNT_W) - 1) begin : g_bad_thresh
      $error("lbuf_entry: THRESH out of counter range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("lbuf_entry: CNT_W must be at least 1");
   end

   logic tgt_ok;
   if (CHECK_TGT) begin : g_tgt_cmp
      assign tgt_ok = (res_tgt == ent_tgt);
   end else begin : g_tgt_any
      assign tgt_ok = 1'b1;
   end

   logic keep_going;
   assign keep_going = res_taken && tgt_ok;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         ent_vld  <= 1'b0;
         ent_cnt  <= '0;
         ent_addr <= '0;
         ent_tgt  <= '0;
      end else if (ld) begin
         ent_vld  <= 1'b1;
         ent_addr <= ld_addr;
         ent_tgt  <= ld_tgt;
         ent_cnt  <= '0;
      end else if (res_hit) begin
         if (keep_going) begin
            if (ent_cnt != CNT_MAX) ent_cnt <= ent_cnt + 1'b1;
         end else begin
            ent_vld <= 1'b0;
            ent_cnt <= '0;
         end
      end
   end

   // R9: a flush always leaves an empty entry
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!ent_vld && ent_cnt == '0));
   // R7: not-taken on the stored address empties the entry
   a_r7_nottaken_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !ld && res_hit && !res_taken) |=> !ent_vld);
   // R8: wrong target on a taken resolution empties the entry
   a_r8_badtgt_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !ld && res_hit && res_taken && CHECK_TGT && (res_tgt != ent_tgt)) |=> !ent_vld);
   // R10: with no event the counter and entry stay put
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !ld && !res_hit) |=> ($stable(ent_cnt) && $stable(ent_vld) && $stable(ent_addr)));
   // R4: the counter never wraps from its maximum
   a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_cnt == CNT_MAX && !flush && !ld && res_hit && res_taken && tgt_ok) |=> ent_cnt == CNT_MAX);
endmodule

// File: rtl/lbuf_out.sv
module lbuf_out
   import lbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TGT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lookup_valid,
   input  logic [ADDR_W-1:0] lookup_addr,
   input  logic              serve_hit,
   input  logic [TGT_W-1:0]  ent_tgt,
   input  logic [TGT_W-1:0]  bpt_rd_data,
   output logic              bpt_rd_en,
   output logic [ADDR_W-1:0] bpt_rd_addr,
   output logic              rd_ret,
   output logic [ADDR_W-1:0] rd_ret_addr,
   output logic              pred_valid,
   output logic [TGT_W-1:0]  pred_target,
   output logic              pred_from_buf
);
   psrc_e            src_q;
   logic [TGT_W-1:0] buf_tgt_q;

   assign bpt_rd_en   = lookup_valid && !serve_hit;
   assign bpt_rd_addr = lookup_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q       <= PSRC_NONE;
         buf_tgt_q   <= '0;
         rd_ret      <= 1'b0;
         rd_ret_addr <= '0;
      end else begin
         rd_ret      <= bpt_rd_en;
         rd_ret_addr <= lookup_addr;
         if (serve_hit) begin
            src_q     <= PSRC_BUF;
            buf_tgt_q <= ent_tgt;
         end else if (lookup_valid) begin
            src_q <= PSRC_TABLE;
         end else begin
            src_q <= PSRC_NONE;
         end
      end
   end

   assign pred_valid    = (src_q != PSRC_NONE);
   assign pred_from_buf = (src_q == PSRC_BUF);
   assign pred_target   = pred_from_buf ? buf_tgt_q : bpt_rd_data;

   // R2: a table read yields a table-sourced prediction next cycle
   a_r2_read_then_table: assert property (@(posedge clk) disable iff (!rst_n)
      bpt_rd_en |=> (pred_valid && !pred_from_buf));
   // R5: a lookup left unread is answered by the buffer next cycle
   a_r5_unread_then_buf: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && !bpt_rd_en) |=> (pred_valid && pred_from_buf));
   // R1: no prediction appears without a lookup
   a_r1_no_spurious_pred: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_valid |=> !pred_valid);
endmodule

// File: rtl/branch_loop_buf.sv
module branch_loop_buf #(
   parameter int ADDR_W    = 32,
   parameter int TGT_W     = 32,
   parameter int CNT_W     = 2,
   parameter int THRESH    = 3,
   parameter bit CHECK_TGT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lookup_valid,
   input  logic [ADDR_W-1:0] lookup_addr,
   output logic              bpt_rd_en,
   output logic [ADDR_W-1:0] bpt_rd_addr,
   input  logic [TGT_W-1:0]  bpt_rd_data,
   input  logic              resolve_valid,
   input  logic [ADDR_W-1:0] resolve_addr,
   input  logic              resolve_taken,
   input  logic [TGT_W-1:0]  resolve_target,
   output logic              pred_valid,
   output logic [TGT_W-1:0]  pred_target,
   output logic              pred_from_buf
);
   if (ADDR_W < 1 || TGT_W < 1) begin : g_bad_width
      $error("branch_loop_buf: widths must be positive");
   end

   logic              ent_vld;
   logic [ADDR_W-1:0] ent_addr;
   logic [TGT_W-1:0]  ent_tgt;
   logic [CNT_W-1:0]  ent_cnt;
   logic              serve_hit;
   logic              res_hit;
   logic              rd_ret;
   logic [ADDR_W-1:0] rd_ret_addr;
   logic              ld;

   // returned table data replaces the entry unless it is for the same address
   assign ld = rd_ret && (!ent_vld || (rd_ret_addr != ent_addr));

   lbuf_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_match (
      .ent_vld       (ent_vld),
      .ent_addr      (ent_addr),
      .ent_cnt       (ent_cnt),
      .flush         (flush),
      .lookup_valid  (lookup_valid),
      .lookup_addr   (lookup_addr),
      .resolve_valid (resolve_valid),
      .resolve_addr  (resolve_addr),
      .serve_hit     (serve_hit),
      .res_hit       (res_hit)
   );

   lbuf_entry #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .CNT_W(CNT_W),
                .THRESH(THRESH), .CHECK_TGT(CHECK_TGT)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .ld        (ld),
      .ld_addr   (rd_ret_addr),
      .ld_tgt    (bpt_rd_data),
      .res_hit   (res_hit),
      .res_taken (resolve_taken),
      .res_tgt   (resolve_target),
      .ent_vld   (ent_vld),
      .ent_addr  (ent_addr),
      .ent_tgt   (ent_tgt),
      .ent_cnt   (ent_cnt)
   );

   lbuf_out #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .lookup_valid  (lookup_valid),
      .lookup_addr   (lookup_addr),
      .serve_hit     (serve_hit),
      .ent_tgt       (ent_tgt),
      .bpt_rd_data   (bpt_rd_data),
      .bpt_rd_en     (bpt_rd_en),
      .bpt_rd_addr   (bpt_rd_addr),
      .rd_ret        (rd_ret),
      .rd_ret_addr   (rd_ret_addr),
      .pred_valid    (pred_valid),
      .pred_target   (pred_target),
      .pred_from_buf (pred_from_buf)
   );

   // R11: a pending table return loads the entry even when a resolution arrives
   a_r11_load_beats_resolve: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !flush) |=> (ent_vld && ent_cnt == '0));
   // R9: a lookup in a flush cycle always reads the table
   a_r9_flush_reads_table: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lookup_valid) |-> bpt_rd_en);
endmodule

// File: tb/sim_branch_loop_buf.sv
module sim_branch_loop_buf;
   localparam int AW = 6;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          lookup_valid = 1'b0;
   logic [AW-1:0] lookup_addr = '0;
   logic          bpt_rd_en;
   logic [AW-1:0] bpt_rd_addr;
   logic [TW-1:0] bpt_rd_data;
   logic          resolve_valid = 1'b0;
   logic [AW-1:0] resolve_addr = '0;
   logic          resolve_taken = 1'b0;
   logic [TW-1:0] resolve_target = '0;
   logic          pred_valid;
   logic [TW-1:0] pred_target;
   logic          pred_from_buf;

   int total = 0;
   int bad = 0;

   // model state built from the requirements
   bit          mv;
   logic [AW-1:0] ma;
   logic [TW-1:0] mt;
   int          mc;
   bit          mp;
   logic [AW-1:0] mpa;

   always #2 clk = ~clk;

   function automatic logic [TW-1:0] tbl(input logic [AW-1:0] a);
      return TW'(int'(a) * 37 + 11);
   endfunction

   // table RAM: synchronous read
   always_ff @(posedge clk) begin
      if (bpt_rd_en) bpt_rd_data <= tbl(bpt_rd_addr);
   end

   branch_loop_buf #(.ADDR_W(AW), .TGT_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
      .bpt_rd_en(bpt_rd_en), .bpt_rd_addr(bpt_rd_addr), .bpt_rd_data(bpt_rd_data),
      .resolve_valid(resolve_valid), .resolve_addr(resolve_addr),
      .resolve_taken(resolve_taken), .resolve_target(resolve_target),
      .pred_valid(pred_valid), .pred_target(pred_target), .pred_from_buf(pred_from_buf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic step(input bit lv, input logic [AW-1:0] la,
                       input bit rv, input logic [AW-1:0] ra, input bit rt,
                       input logic [TW-1:0] rtg, input bit fl, input string tag);
      bit exp_hit, exp_rd;
      bit nv; logic [AW-1:0] na; logic [TW-1:0] nt; int nc;
      lookup_valid = lv; lookup_addr = la; flush = fl;
      resolve_valid = rv; resolve_addr = ra; resolve_taken = rt; resolve_target = rtg;
      #1;
      exp_hit = lv && !fl && mv && (mc == 3) && (la == ma);
      exp_rd  = lv && !exp_hit;
      chk(bpt_rd_en == exp_rd, tag, int'(bpt_rd_en), int'(exp_rd));
      if (exp_rd) chk(bpt_rd_addr == la, tag, int'(bpt_rd_addr), int'(la));
      nv = mv; na = ma; nt = mt; nc = mc;
      if (fl) begin
         nv = 0; nc = 0;
      end else if (mp && (!mv || mpa != ma)) begin
         nv = 1; na = mpa; nt = tbl(mpa); nc = 0;
      end else if (rv && mv && ra == ma) begin
         if (rt && rtg == mt) begin
            if (nc < 3) nc = nc + 1;
         end else begin
            nv = 0; nc = 0;
         end
      end
      @(posedge clk); #1;
      chk(pred_valid == lv, tag, int'(pred_valid), int'(lv));
      if (lv) begin
         chk(pred_from_buf == exp_hit, tag, int'(pred_from_buf), int'(exp_hit));
         chk(pred_target == tbl(la), "R6", int'(pred_target), int'(tbl(la)));
      end
      mv = nv; ma = na; mt = nt; mc = nc;
      mp = exp_rd; mpa = la;
      lookup_valid = 0; resolve_valid = 0; flush = 0;
   endtask

   task automatic look(input logic [AW-1:0] a, input string tag);
      step(1, a, 0, '0, 0, '0, 0, tag);
   endtask
   task automatic take(input logic [AW-1:0] a, input string tag);
      step(0, '0, 1, a, 1, tbl(a), 0, tag);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] lf;
      logic [AW-1:0] pool [4];
      mv = 0; ma = '0; mt = '0; mc = 0; mp = 0; mpa = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(bpt_rd_en == 0, "R1", int'(bpt_rd_en), 0);
      chk(pred_valid == 0, "R1", int'(pred_valid), 0);
      rst_n = 1;
      @(posedge clk); #1;
      chk(pred_valid == 0, "R1", int'(pred_valid), 0);
      look(6'd5, "R1");                 // first lookup reads table
      look(6'd5, "R2");                 // same address: entry unchanged, reads table
      // R3/R4: three good taken resolutions train the entry
      take(6'd5, "R3"); take(6'd5, "R4");
      look(6'd5, "R4");                 // count 2: still table
      take(6'd5, "R4");
      look(6'd5, "R5");                 // count 3: served
      look(6'd5, "R5");
      take(6'd5, "R4");                 // saturation
      take(6'd5, "R4");
      look(6'd5, "R4");
      // R10: other-address resolutions are ignored
      step(0, '0, 1, 6'd9, 0, '0, 0, "R10");
      look(6'd5, "R10");
      // R7: not taken empties
      step(0, '0, 1, 6'd5, 0, tbl(6'd5), 0, "R7");
      look(6'd5, "R7");
      look(6'd5, "R7");
      // retrain then R8: wrong target empties
      take(6'd5, "R8"); take(6'd5, "R8"); take(6'd5, "R8");
      look(6'd5, "R8");
      step(0, '0, 1, 6'd5, 1, tbl(6'd5) ^ 8'h01, 0, "R8");
      look(6'd5, "R8");
      look(6'd5, "R8");
      // retrain then R9: flush with same-cycle lookup
      take(6'd5, "R9"); take(6'd5, "R9"); take(6'd5, "R9");
      step(1, 6'd5, 0, '0, 0, '0, 1, "R9");
      look(6'd5, "R9");
      // R3: new address overwrites; R11 load beats resolve in same cycle
      take(6'd5, "R3"); take(6'd5, "R3"); take(6'd5, "R3");
      look(6'd20, "R3");
      step(0, '0, 1, 6'd5, 1, tbl(6'd5), 0, "R11");
      look(6'd5, "R11");
      look(6'd20, "R11");
      // R11: flush beats a pending load
      look(6'd33, "R11");
      step(0, '0, 0, '0, 0, '0, 1, "R11");
      take(6'd33, "R11");
      look(6'd33, "R11");
      // mixed sweep
      pool[0] = 6'd5; pool[1] = 6'd9; pool[2] = 6'd20; pool[3] = 6'd63;
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         bit lv, rv, rt, fl;
         logic [AW-1:0] la, ra;
         logic [TW-1:0] rtg;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         lv = lf[0] | lf[1];
         la = (lf[2] & lf[3]) ? pool[lf[5:4]] : pool[0];
         rv = lf[6] | lf[7];
         ra = (lf[8] & lf[9]) ? pool[lf[11:10]] : pool[0];
         rt = (lf[12] | lf[13] | lf[14]);
         rtg = (lf[15] & lf[3] & lf[9]) ? tbl(ra) ^ 8'h80 : tbl(ra);
         fl = (lf[1:0] == 2'b00) && lf[14] && lf[6];
         step(lv, la, rv, ra, rt, rtg, fl, "R11");
      end
      summary();
      $finish;
   end
endmodule